// File: doc/BRIEF.md
# Conditional Execution Gate

This block decides whether a conditionally executed instruction is allowed to take effect. It receives the 4-bit condition field of the instruction together with the four status flags (negative, zero, carry, overflow) and returns one execute-enable bit. The block tests single flags. It also forms the unsigned comparisons (higher, lower-or-same) and the signed comparisons (greater-or-equal, less-than, greater-than, less-or-equal) from combinations of the flags.

Two forms of the decision are provided. A combinational enable is available for decode logic in the same cycle. A registered enable captures the decision qualified by an instruction-valid strobe, so it can gate the next pipeline stage directly. The block does not produce the flags, does not decode the rest of the instruction and does not handle a suppressed instruction.

Top module: `ccx_gate`

## Requirements
- R1: Code 0000 passes when the zero flag is 1. Code 0001 passes when the zero flag is 0.
- R2: Code 0010 passes when the carry flag is 1. Code 0011 passes when the carry flag is 0.
- R3: Code 0100 passes when the negative flag is 1. Code 0101 passes when the negative flag is 0.
- R4: Code 0110 passes when the overflow flag is 1. Code 0111 passes when the overflow flag is 0.
- R5: Code 1000 (unsigned higher) passes when carry is 1 and zero is 0. Code 1001 (unsigned lower-or-same) passes when zero is 1 or carry is 0.
- R6: Code 1010 (signed greater-or-equal) passes when negative equals overflow. Code 1011 (signed less-than) passes when they differ.
- R7: Code 1100 (signed greater-than) passes when negative equals overflow and zero is 0. Code 1101 (signed less-or-equal) passes when zero is 1 or negative differs from overflow.
- R8: Code 1110 always passes, whatever the flags are.
- R9: Code 1111 never passes, whatever the flags are.
- R10: `exec_q_o` equals, one clock after the edge, the logical AND of `instr_valid_i` and the combinational decision sampled at that edge. It is 0 whenever `instr_valid_i` was low.
- R11: While `rst` is high at a clock edge, `exec_q_o` is 0 after that edge.
- R12: For every even code below 1110, the decision for that code and the decision for the next odd code are complements for the same flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cond_i | input | 4 | Condition field of the instruction |
| flag_n_i | input | 1 | Negative flag |
| flag_z_i | input | 1 | Zero flag |
| flag_c_i | input | 1 | Carry flag |
| flag_v_i | input | 1 | Overflow flag |
| instr_valid_i | input | 1 | Instruction-valid strobe |
| exec_o | output | 1 | Combinational execute enable |
| exec_q_o | output | 1 | Registered execute enable, qualified by valid |

## Verification
The assertions are evaluated on every clock. They cover the always and never codes, the zero-flag pair, the unsigned and signed compound predicates, the registered enable following valid AND decision, and the clear after reset. Only the bench's scenarios show two further properties. The first is that every code/flag combination (all 256, with valid both high and low) gives the correct result. The second is that each even/odd pair gives opposite answers for the same flags, which requires comparing results taken at different times. A reset applied while a passing, valid instruction is present is also shown only by a bench scenario.

// File: rtl/ccx_pkg.sv
package ccx_pkg;
  localparam int COND_W = 4;
  localparam int GRP_W  = COND_W - 1;

  // Pair groups: the upper three condition bits select a predicate, the low bit inverts it
  localparam logic [GRP_W-1:0] GRP_ZERO  = 3'd0;
  localparam logic [GRP_W-1:0] GRP_CARRY = 3'd1;
  localparam logic [GRP_W-1:0] GRP_NEG   = 3'd2;
  localparam logic [GRP_W-1:0] GRP_OVF   = 3'd3;
  localparam logic [GRP_W-1:0] GRP_UHI   = 3'd4;
  localparam logic [GRP_W-1:0] GRP_SGE   = 3'd5;
  localparam logic [GRP_W-1:0] GRP_SGT   = 3'd6;
  localparam logic [GRP_W-1:0] GRP_FIXED = 3'd7;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;
endpackage

// File: rtl/ccx_predicate.sv
module ccx_predicate
  import ccx_pkg::*;
(
  input  logic [COND_W-1:0] cond_i,
  input  flags_t            flags_i,
  output logic              pass_o
);
  logic [GRP_W-1:0] grp;
  logic             invert;
  logic             base;
  logic             signs_agree;

  assign grp         = cond_i[COND_W-1:1];
  assign invert      = cond_i[0];
  assign signs_agree = ~(flags_i.n ^ flags_i.v);

  always_comb begin
    case (grp)
      GRP_ZERO:  base = flags_i.z;
      GRP_CARRY: base = flags_i.c;
      GRP_NEG:   base = flags_i.n;
      GRP_OVF:   base = flags_i.v;
      GRP_UHI:   base = flags_i.c & ~flags_i.z;
      GRP_SGE:   base = signs_agree;
      GRP_SGT:   base = signs_agree & ~flags_i.z;
      default:   base = 1'b1;
    endcase
  end

  // The fixed group (always/never) uses the same inversion as the others
  assign pass_o = base ^ invert;
endmodule

// File: rtl/ccx_stage.sv
module ccx_stage #(
  parameter int          W         = 1,
  parameter logic [W-1:0] RESET_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (rst) q_o <= RESET_VAL;
    else     q_o <= d_i;
  end
endmodule

// File: rtl/ccx_gate.sv
module ccx_gate
  import ccx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [COND_W-1:0] cond_i,
  input  logic              flag_n_i,
  input  logic              flag_z_i,
  input  logic              flag_c_i,
  input  logic              flag_v_i,
  input  logic              instr_valid_i,
  output logic              exec_o,
  output logic              exec_q_o
);
  flags_t flags;
  logic   pass;
  logic   qualified;

  assign flags = '{n: flag_n_i, z: flag_z_i, c: flag_c_i, v: flag_v_i};

  ccx_predicate pred_i (
    .cond_i  (cond_i),
    .flags_i (flags),
    .pass_o  (pass)
  );

  assign exec_o    = pass;
  assign qualified = instr_valid_i & pass;

  ccx_stage #(.W(1), .RESET_VAL(1'b0)) stage_i (
    .clk (clk),
    .rst (rst),
    .d_i (qualified),
    .q_o (exec_q_o)
  );

  assert_zero_pair_R1: assert property (@(posedge clk) disable iff (rst)
    (cond_i[COND_W-1:1] == 3'd0) |-> (exec_o == (flag_z_i ^ cond_i[0])));
  assert_unsigned_hi_R5: assert property (@(posedge clk) disable iff (rst)
    (cond_i == 4'b1000) |-> (exec_o == (flag_c_i && !flag_z_i)));
  assert_signed_ge_R6: assert property (@(posedge clk) disable iff (rst)
    (cond_i == 4'b1010) |-> (exec_o == (flag_n_i == flag_v_i)));
  assert_signed_le_R7: assert property (@(posedge clk) disable iff (rst)
    (cond_i == 4'b1101) |-> (exec_o == (flag_z_i || (flag_n_i != flag_v_i))));
  assert_always_R8: assert property (@(posedge clk) disable iff (rst)
    (cond_i == 4'b1110) |-> exec_o);
  assert_never_R9: assert property (@(posedge clk) disable iff (rst)
    (cond_i == 4'b1111) |-> !exec_o);
  assert_reg_follow_R10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (exec_q_o == $past(instr_valid_i && exec_o)));
  assert_reset_clear_R11: assert property (@(posedge clk)
    $past(rst) |-> !exec_q_o);
endmodule

// File: tb/ccx_gate_tb_top.sv
`timescale 1ns/1ps
module ccx_gate_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] cond = 4'd0;
  logic       fn = 1'b0, fz = 1'b0, fc = 1'b0, fv = 1'b0;
  logic       valid = 1'b0;
  logic       exec_c, exec_q;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  ccx_gate dut_i (
    .clk(clk), .rst(rst), .cond_i(cond),
    .flag_n_i(fn), .flag_z_i(fz), .flag_c_i(fc), .flag_v_i(fv),
    .instr_valid_i(valid), .exec_o(exec_c), .exec_q_o(exec_q)
  );

  // Behavioural reference: mnemonic-level meaning of each code
  function automatic bit ref_pass(int code, bit n, bit z, bit c, bit v);
    if (code == 0)  return z;
    if (code == 1)  return !z;
    if (code == 2)  return c;
    if (code == 3)  return !c;
    if (code == 4)  return n;
    if (code == 5)  return !n;
    if (code == 6)  return v;
    if (code == 7)  return !v;
    if (code == 8)  return c && !z;
    if (code == 9)  return z || !c;
    if (code == 10) return n == v;
    if (code == 11) return n != v;
    if (code == 12) return (n == v) && !z;
    if (code == 13) return z || (n != v);
    if (code == 14) return 1;
    return 0;
  endfunction

  function automatic string req_of(int code);
    case (code / 2)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      5: return "R6";
      6: return "R7";
      default: return (code == 14) ? "R8" : "R9";
    endcase
  endfunction

  task automatic check(string req, logic actual, logic expected, string what);
    checks++;
    if (actual !== expected) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, actual, expected);
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    bit pend;
    bit pend_exp;
    bit res [16];
    pend = 0;
    pend_exp = 0;
    // R11: registered output held at zero during reset
    valid = 1'b1; cond = 4'd14;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R11", exec_q, 1'b0, "reset state");
    rst = 1'b0;

    for (int fl = 0; fl < 16; fl++) begin
      for (int code = 0; code < 16; code++) begin
        for (int vl = 0; vl < 2; vl++) begin
          bit e;
          @(negedge clk);
          if (pend) check("R10", exec_q, pend_exp, "registered enable");
          cond = code[3:0];
          fn = fl[3]; fz = fl[2]; fc = fl[1]; fv = fl[0];
          valid = vl[0];
          #1;
          e = ref_pass(code, fl[3], fl[2], fl[1], fl[0]);
          check(req_of(code), exec_c, e, $sformatf("code=%0d flags=%04b", code, fl));
          res[code] = exec_c;
          pend = 1;
          pend_exp = e && vl[0];
        end
      end
      // R12: even/odd pairs give opposite answers for identical flags
      for (int k = 0; k < 7; k++)
        check("R12", res[2*k] ^ res[2*k+1], 1'b1, $sformatf("pair %0d flags=%04b", k, fl));
    end

    @(negedge clk);
    if (pend) check("R10", exec_q, pend_exp, "registered enable final");

    // R11: reset while a valid passing instruction is present
    cond = 4'd14; valid = 1'b1;
    @(negedge clk);
    check("R10", exec_q, 1'b1, "valid always before reset");
    rst = 1'b1;
    @(negedge clk);
    check("R11", exec_q, 1'b0, "reset mid-run");
    rst = 1'b0;
    @(negedge clk);
    check("R10", exec_q, 1'b1, "recovers after reset");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule